// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the address of each beat in a four-beat burst for a synchronous, pipelined memory. When a burst starts, it captures the whole incoming address. The upper bits are then held for the rest of the burst. Only the two lowest bits move from beat to beat.

A per-burst ordering choice picks one of two orders:

- **Linear:** the offset counts up modulo four from the starting offset.
- **Interleaved:** the offset is the starting offset XORed with the beat number.

The ordering input is sampled when the burst starts. A board that leaves this pin floating should drive it high, because interleaved is the default order.

A controller pulses `burst_start` with the first address. It then pulses `beat_adv` once for each further beat. The block has no burst-end flag. Advancing past the fourth beat simply wraps to the first beat's offset. All pins are plain control and address signals, with no handshake. The output is available in the cycle after the edge that loads or advances it. Every width is a parameter. The defaults are a 20-bit address with a 2-bit offset.

Top module: `burst_seq`

## Requirements
- R1: In the cycle after a clock edge where `burst_start` is high, `addr_out` equals the `addr_in` value sampled at that edge.
- R2: The upper bits of `addr_out` (all bits above bit 1) keep the value captured at the last burst start until the next burst start or reset, whatever `beat_adv` does.
- R3: With linear order latched (`order_sel` low at burst start), beat k has offset bits [1:0] equal to (start offset + k) mod 4. For example, start 2'b10 gives 10, 11, 00, 01.
- R4: With interleaved order latched (`order_sel` high at burst start), beat k has offset bits [1:0] equal to start offset XOR k. For example, start 2'b01 gives 01, 00, 11, 10.
- R5: `order_sel` is sampled only at burst start. Changing it in the middle of a burst has no effect on the offsets of that burst.
- R6: Each clock edge with `beat_adv` high and `burst_start` low moves to the next beat. With both low, `addr_out` holds its value.
- R7: After the fourth beat, a further advance wraps the offset back to the first beat's value. No state blocks this.
- R8: When `burst_start` and `beat_adv` are high at the same edge, the burst restarts at beat zero with the new address, and the advance is dropped.
- R9: While `rst_n` is low at a clock edge, the state is cleared: `addr_out` becomes 0, the beat count becomes 0 and the latched order becomes interleaved. Reset overrides `burst_start`.
- R10: `addr_in` is ignored at any edge where `burst_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_start | input | 1 | Captures `addr_in` and `order_sel` and begins a burst at beat zero |
| beat_adv | input | 1 | Steps to the next beat |
| order_sel | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | Starting address of the burst |
| addr_out | output | ADDR_W | Latched upper bits joined with the current beat offset |

## Verification
The hardest situations to reach from the ports are a fifth advance, a start that arrives in the same cycle as an advance, and a change of `order_sel` partway through a burst. Random stimulus alone rarely lines these up against a known start offset. Directed sequences therefore drive each of them explicitly, for both orders and for starting offsets that expose the difference between counting up and XOR. A long seeded random run then mixes starts, advances, idle cycles and order flips. In that run, `addr_in` toggles freely while no start is asserted, so any leak of new address bits into a burst shows up.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Ordering applied to the low offset bits of a burst.
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } ord_e;

  // Default ordering out of reset (interleaved, matching a floating select).
  localparam ord_e ORD_RESET = ORD_XOR;

  // Linear step: start + beat, truncated to the offset width by the caller.
  function automatic logic [7:0] ofs_linear(input logic [7:0] s, input logic [7:0] k);
    return s + k;
  endfunction

  // Interleaved step: start XOR beat.
  function automatic logic [7:0] ofs_xor(input logic [7:0] s, input logic [7:0] k);
    return s ^ k;
  endfunction

endpackage

// File: rtl/burst_seq_latch.sv
module burst_seq_latch
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2,
  localparam int HI_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ord_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [HI_W-1:0]   hi_q,
  output logic [OFS_W-1:0]  ofs0_q,
  output ord_e              ord_q
);

  // Capture the upper address, start offset and order on a burst start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      ofs0_q <= '0;
      ord_q  <= ORD_RESET;
    end else if (load) begin
      hi_q   <= addr_in[ADDR_W-1:OFS_W];
      ofs0_q <= addr_in[OFS_W-1:0];
      ord_q  <= ord_e'(ord_in);
    end
  end

  AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hi_q)); // R2

  AST_ORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ord_q)); // R5

  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ofs0_q)); // R10

  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hi_q == $past(addr_in[ADDR_W-1:OFS_W])); // R1

endmodule

// File: rtl/burst_seq_ctr.sv
module burst_seq_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [OFS_W-1:0] beat_q
);

  // Beat counter: cleared on start, wraps naturally at its width.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (clear) begin
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> beat_q == '0); // R8

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step) |=> beat_q == OFS_W'($past(beat_q) + 1'b1)); // R6

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(beat_q)); // R6

endmodule

// File: rtl/burst_seq_ofs.sv
module burst_seq_ofs
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] start_ofs,
  input  logic [OFS_W-1:0] beat,
  input  ord_e             ord,
  output logic [OFS_W-1:0] ofs
);

  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] xor_ofs;

  // Each ordering is built bit by bit: the linear one as a ripple adder
  // that drops its carry out, the interleaved one as a plain XOR.
  logic [OFS_W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < OFS_W; i++) begin : g_bit
    assign lin_ofs[i]   = start_ofs[i] ^ beat[i] ^ carry[i];
    assign carry[i+1]   = (start_ofs[i] & beat[i]) | (carry[i] & (start_ofs[i] ^ beat[i]));
    assign xor_ofs[i]   = start_ofs[i] ^ beat[i];
  end

  always_comb begin
    unique case (ord)
      ORD_LINEAR: ofs = lin_ofs;
      ORD_XOR:    ofs = xor_ofs;
      default:    ofs = xor_ofs;
    endcase
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_start,
  input  logic              beat_adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int HI_W = ADDR_W - OFS_W;

  logic [HI_W-1:0]  hi_q;
  logic [OFS_W-1:0] ofs0_q;
  logic [OFS_W-1:0] beat_q;
  logic [OFS_W-1:0] cur_ofs;
  ord_e             ord_q;
  logic             step;

  // Start wins over advance in the same cycle.
  assign step = beat_adv & ~burst_start;

  burst_seq_latch #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (burst_start),
    .ord_in  (order_sel),
    .addr_in (addr_in),
    .hi_q    (hi_q),
    .ofs0_q  (ofs0_q),
    .ord_q   (ord_q)
  );

  burst_seq_ctr #(.OFS_W(OFS_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (burst_start),
    .step   (step),
    .beat_q (beat_q)
  );

  burst_seq_ofs #(.OFS_W(OFS_W)) u_ofs (
    .start_ofs (ofs0_q),
    .beat      (beat_q),
    .ord       (ord_q),
    .ofs       (cur_ofs)
  );

  assign addr_out = {hi_q, cur_ofs};

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> addr_out == $past(addr_in)); // R1

  AST_WRAP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (step && beat_q == '1) |=> addr_out[OFS_W-1:0] == ofs0_q); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_start && !beat_adv) |=> $stable(addr_out)); // R6

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ord_q == ORD_LINEAR) |=>
      addr_out[OFS_W-1:0] == OFS_W'($past(addr_out[OFS_W-1:0]) + 1'b1)); // R3

endmodule

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          burst_start;
  logic          beat_adv;
  logic          order_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // Reference state built from the requirements.
  logic [AW-3:0] m_hi;
  logic [1:0]    m_s;
  logic [1:0]    m_k;
  logic          m_ilv;

  always #2 clk = ~clk;

  burst_seq #(.ADDR_W(AW), .OFS_W(2)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .beat_adv    (beat_adv),
    .order_sel   (order_sel),
    .addr_in     (addr_in),
    .addr_out    (addr_out)
  );

  function automatic logic [AW-1:0] expect_addr();
    logic [1:0] o;
    o = m_ilv ? (m_s ^ m_k) : 2'(m_s + m_k);
    return {m_hi, o};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: addr_out=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle, update the model at the edge, compare at the next negedge.
  task automatic cyc(input logic r, input logic s, input logic a, input logic m,
                     input logic [AW-1:0] ai, input string req);
    rst_n = r; burst_start = s; beat_adv = a; order_sel = m; addr_in = ai;
    @(posedge clk);
    if (!r) begin
      m_hi = '0; m_s = '0; m_k = '0; m_ilv = 1'b1;
    end else if (s) begin
      m_hi = ai[AW-1:2]; m_s = ai[1:0]; m_k = '0; m_ilv = m;
    end else if (a) begin
      m_k = m_k + 2'd1;
    end
    @(negedge clk);
    check(req, addr_out, expect_addr());
  endtask

  initial begin
    #400000;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] ra;
    void'($urandom(32'd2024));
    rst_n = 1'b0; burst_start = 1'b0; beat_adv = 1'b0; order_sel = 1'b0; addr_in = '0;
    m_hi = '0; m_s = '0; m_k = '0; m_ilv = 1'b1;
    @(negedge clk);

    // R9: reset clears and overrides a start
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 20'hABCDE, "R9");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 20'h0, "R9");
    check("R9", addr_out, 20'h0);

    // R3, R7: linear from start 10: 10,11,00,01 then wrap to 10
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 20'h12346, "R1");
    check("R3", addr_out, 20'h12346);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h0, "R3"); check("R3", addr_out, 20'h12347);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h0, "R3"); check("R3", addr_out, 20'h12344);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h0, "R3"); check("R3", addr_out, 20'h12345);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h0, "R7"); check("R7", addr_out, 20'h12346);

    // R4: interleaved from start 01: 01,00,11,10; R5: order flips ignored mid-burst
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 20'hF0F01, "R1");
    check("R4", addr_out, 20'hF0F01);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h0, "R5"); check("R4", addr_out, 20'hF0F00);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h0, "R5"); check("R4", addr_out, 20'hF0F03);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 20'h0, "R4"); check("R4", addr_out, 20'hF0F02);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h0, "R7"); check("R7", addr_out, 20'hF0F01);

    // R6, R10, R2: hold with random addr_in and no start
    for (int i = 0; i < 6; i++) begin
      ra = AW'($urandom());
      cyc(1'b1, 1'b0, 1'b0, ra[0], ra, "R10");
      check("R6", addr_out, 20'hF0F01);
    end

    // R8: start together with advance lands on beat zero
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 20'h5555A, "R8");
    check("R8", addr_out, 20'h5555A);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'hFFFFF, "R2");
    check("R2", addr_out, 20'h5555B);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic s, a, m, r;
      ra = AW'($urandom());
      r = ($urandom() % 64) != 0;
      s = ($urandom() % 8) == 0;
      a = ($urandom() % 4) != 0;
      m = $urandom() % 2;
      if (!r) cyc(r, s, a, m, ra, "R9");
      else if (s) cyc(r, s, a, m, ra, a ? "R8" : "R1");
      else if (!a) cyc(r, s, a, m, ra, "R6");
      else if (m_ilv) cyc(r, s, a, m, ra, "R4");
      else cyc(r, s, a, m, ra, "R3");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule